// File: doc/BRIEF.md
# Dual Framebuffer Fetch Address Engine

This block walks a frame held in memory and streams its words into a pixel FIFO. It has two framebuffer descriptors. Each descriptor holds a start address and a ceiling, and the ceiling is the address of the buffer's last byte, so it equals start + size − 1. The engine issues one read burst at a time over a request/accept handshake. It writes each returned word into the FIFO, after optional byte reordering. When a buffer pass is complete it pulses an end-of-buffer flag, and software may then load new addresses for that buffer.

In single mode the engine fetches buffer 0 over and over. In dual mode it fetches buffer 0 and buffer 1 in turn on successive frames, which gives software a ping-pong scheme. The burst length is programmed as a power of two. A burst never reads past the ceiling. A burst is only issued when the FIFO has room for all of its words. The engine also reports two things about the FIFO: when the fill level has reached a programmable threshold, and when the pixel consumer pops from an empty FIFO.

Top module: `fb_fetch_engine`

## Requirements
- R1: After reset, mem_req, fifo_wr, eof0, eof1, pix_ready and underflow are all low.
- R2: In single mode (control bit 0 = 0), each pass reads buffer 0 from its start word up to and including its ceiling word, in ascending addresses. Every pass ends with a one-cycle eof0 pulse, and eof1 never pulses.
- R3: In dual mode (control bit 0 = 1), passes alternate between buffer 0 and buffer 1, starting with buffer 0. The end of a buffer-0 pass pulses eof0 and the end of a buffer-1 pass pulses eof1. The two never pulse together.
- R4: Control bits [6:4] = n with n from 0 to 4 gives bursts of 2^n words. The values 5 to 7 give 16 words. mem_len carries the burst length in words.
- R5: The last burst of a pass is shortened so that its last word is the ceiling word. Address bits [1:0] of the start and the ceiling are ignored, so all fetches are word aligned.
- R6: The start and ceiling of a buffer are captured when its pass begins. A write to them during a pass takes effect from that buffer's next pass.
- R7: Control bit 3 swaps the two bytes inside each 16-bit half of a fetched word. Control bit 1 exchanges the two halves. With both bits set, the byte order is fully reversed.
- R8: pix_ready is high one cycle after fifo_level is at least min(8·2^k, FIFO_DEPTH), where k is control bits [10:8].
- R9: underflow pulses high for one cycle, on the cycle after pix_pop is high while fifo_level is 0. It stays low otherwise.
- R10: A burst is requested only when fifo_level + burst length ≤ FIFO_DEPTH.
- R11: mem_req, mem_addr and mem_len stay steady until mem_accept is seen. Only one burst is in flight at a time. Each data beat appears on fifo_wr/fifo_wdata exactly one cycle later, and in order.
- R12: Control bit 12 is the run bit. Setting it starts fetching. Clearing it stops the engine at the end of the current burst, and the next start begins with buffer 0.
- R13: cfg_sel selects the register being written: 0 is control, 1 is buffer-0 start, 2 is buffer-0 ceiling, 3 is buffer-1 start, 4 is buffer-1 ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | AW | Byte address of the burst's first word |
| mem_len | output | MAX_BURST_LOG+1 | Burst length in words |
| mem_accept | input | 1 | Memory has taken the request |
| mem_rvalid | input | 1 | Read data beat valid |
| mem_rdata | input | 32 | Read data beat |
| fifo_level | input | LVL_W | Words currently held in the pixel FIFO |
| pix_pop | input | 1 | Consumer pops a word from the FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| pix_ready | output | 1 | FIFO fill level has reached the threshold |
| eof0 | output | 1 | Buffer-0 pass finished |
| eof1 | output | 1 | Buffer-1 pass finished |
| underflow | output | 1 | Pop from an empty FIFO seen |

## Verification
A wrong address counter or a bad latched ceiling shows up on the very next request. mem_addr or mem_len differs from the sequence worked out from the start, ceiling and burst code, and a pass never closes with its end flag. A buffer-select state that fails to toggle or reset shows up at the first pass boundary: the eof0/eof1 order and the next burst address do not match. Broken byte steering shows up on fifo_wdata one cycle after the affected beat.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    // register select codes
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_BASE0 = 3'd1;
    localparam logic [2:0] SEL_CEIL0 = 3'd2;
    localparam logic [2:0] SEL_BASE1 = 3'd3;
    localparam logic [2:0] SEL_CEIL1 = 3'd4;

    // control word bit positions
    localparam int CB_DUAL  = 0;
    localparam int CB_HALF  = 1;
    localparam int CB_BYTE  = 3;
    localparam int CB_BURST = 4;
    localparam int CB_THR   = 8;
    localparam int CB_RUN   = 12;

    typedef struct packed {
        logic       run;
        logic [2:0] thr_log;
        logic [2:0] burst_log;
        logic       byte_swap;
        logic       half_swap;
        logic       dual;
    } fbf_ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_REQ   = 3'd2,
        ST_DATA  = 3'd3,
        ST_GAP   = 3'd4
    } fbf_state_e;

endpackage

// File: rtl/fbf_regs.sv
module fbf_regs
    import fbf_pkg::*;
#(
    parameter int AW = 32,
    localparam int WAW = AW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [31:0]     cfg_wdata,
    output fbf_ctrl_t       ctrl,
    output logic [WAW-1:0]  base0_w,
    output logic [WAW-1:0]  ceil0_w,
    output logic [WAW-1:0]  base1_w,
    output logic [WAW-1:0]  ceil1_w
);

    typedef struct packed {
        fbf_ctrl_t      ctrl;
        logic [WAW-1:0] b0;
        logic [WAW-1:0] c0;
        logic [WAW-1:0] b1;
        logic [WAW-1:0] c1;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL: begin
                    regs_d.ctrl.dual      = cfg_wdata[CB_DUAL];
                    regs_d.ctrl.half_swap = cfg_wdata[CB_HALF];
                    regs_d.ctrl.byte_swap = cfg_wdata[CB_BYTE];
                    regs_d.ctrl.burst_log = cfg_wdata[CB_BURST +: 3];
                    regs_d.ctrl.thr_log   = cfg_wdata[CB_THR +: 3];
                    regs_d.ctrl.run       = cfg_wdata[CB_RUN];
                end
                SEL_BASE0: regs_d.b0 = cfg_wdata[AW-1:2];
                SEL_CEIL0: regs_d.c0 = cfg_wdata[AW-1:2];
                SEL_BASE1: regs_d.b1 = cfg_wdata[AW-1:2];
                SEL_CEIL1: regs_d.c1 = cfg_wdata[AW-1:2];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl    = regs_q.ctrl;
    assign base0_w = regs_q.b0;
    assign ceil0_w = regs_q.c0;
    assign base1_w = regs_q.b1;
    assign ceil1_w = regs_q.c1;

endmodule

// File: rtl/fbf_burst_calc.sv
module fbf_burst_calc #(
    parameter int WAW = 30,
    parameter int MAX_BURST_LOG = 4,
    localparam int LEN_W = MAX_BURST_LOG + 1,
    localparam int RW = WAW + 1
) (
    input  logic [2:0]       burst_log,
    input  logic [WAW-1:0]   cur_w,
    input  logic [WAW-1:0]   ceil_w,
    output logic [LEN_W-1:0] len
);

    logic [LEN_W-1:0] full_len;
    logic [RW-1:0]    remain;

    always_comb begin
        // codes above the largest supported length fall back to the maximum
        if (burst_log > 3'(MAX_BURST_LOG))
            full_len = LEN_W'(1) << MAX_BURST_LOG;
        else
            full_len = LEN_W'(1) << burst_log;
        remain = {1'b0, ceil_w} - {1'b0, cur_w} + RW'(1);
        if (remain < RW'(full_len))
            len = remain[LEN_W-1:0];
        else
            len = full_len;
    end

endmodule

// File: rtl/fbf_byte_order.sv
module fbf_byte_order (
    input  logic [31:0] din,
    input  logic        byte_swap,
    input  logic        half_swap,
    output logic [31:0] dout
);

    logic [31:0] inner;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign inner[16*h +: 16] = byte_swap ? {din[16*h +: 8], din[16*h+8 +: 8]}
                                             : din[16*h +: 16];
    end

    assign dout = half_swap ? {inner[15:0], inner[31:16]} : inner;

endmodule

// File: rtl/fb_fetch_engine.sv
module fb_fetch_engine
    import fbf_pkg::*;
#(
    parameter int AW = 32,
    parameter int FIFO_DEPTH = 256,
    parameter int MAX_BURST_LOG = 4,
    localparam int WAW = AW - 2,
    localparam int RW = WAW + 1,
    localparam int LEN_W = MAX_BURST_LOG + 1,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [LEN_W-1:0] mem_len,
    input  logic             mem_accept,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             pix_pop,
    output logic             fifo_wr,
    output logic [31:0]      fifo_wdata,
    output logic             pix_ready,
    output logic             eof0,
    output logic             eof1,
    output logic             underflow
);

    localparam logic [31:0] DEPTH_L = 32'(FIFO_DEPTH);

    typedef struct packed {
        fbf_state_e       st;
        logic             sel;
        logic [WAW-1:0]   cur_w;
        logic [WAW-1:0]   ceil_w;
        logic [LEN_W-1:0] beats;
        logic             wr;
        logic [31:0]      wdata;
        logic             eof0;
        logic             eof1;
        logic             ready;
        logic             uflow;
    } eng_t;

    eng_t eng_d, eng_q;

    fbf_ctrl_t      ctrl;
    logic [WAW-1:0] base0_w, ceil0_w, base1_w, ceil1_w;
    logic [LEN_W-1:0] len;
    logic [31:0]    ordered;
    logic [31:0]    thr;
    logic           room;
    logic           req_c;

    fbf_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .ctrl     (ctrl),
        .base0_w  (base0_w),
        .ceil0_w  (ceil0_w),
        .base1_w  (base1_w),
        .ceil1_w  (ceil1_w)
    );

    fbf_burst_calc #(.WAW(WAW), .MAX_BURST_LOG(MAX_BURST_LOG)) u_burst (
        .burst_log(ctrl.burst_log),
        .cur_w    (eng_q.cur_w),
        .ceil_w   (eng_q.ceil_w),
        .len      (len)
    );

    fbf_byte_order u_order (
        .din      (mem_rdata),
        .byte_swap(ctrl.byte_swap),
        .half_swap(ctrl.half_swap),
        .dout     (ordered)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.wr   = 1'b0;
        eng_d.eof0 = 1'b0;
        eng_d.eof1 = 1'b0;
        req_c      = 1'b0;

        thr = 32'd8 << ctrl.thr_log;
        if (thr > DEPTH_L) thr = DEPTH_L;
        eng_d.ready = (32'(fifo_level) >= thr);
        eng_d.uflow = pix_pop && (fifo_level == '0);
        room = (32'(fifo_level) + 32'(len)) <= DEPTH_L;

        case (eng_q.st)
            ST_IDLE: begin
                if (ctrl.run) eng_d.st = ST_START;
            end
            ST_START: begin
                eng_d.cur_w  = eng_q.sel ? base1_w : base0_w;
                eng_d.ceil_w = eng_q.sel ? ceil1_w : ceil0_w;
                eng_d.st     = ST_REQ;
            end
            ST_REQ: begin
                if (room) begin
                    req_c = 1'b1;
                    if (mem_accept) begin
                        eng_d.beats = len;
                        eng_d.st    = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (mem_rvalid) begin
                    eng_d.wr    = 1'b1;
                    eng_d.wdata = ordered;
                    eng_d.cur_w = eng_q.cur_w + 1'b1;
                    eng_d.beats = eng_q.beats - 1'b1;
                    if (eng_q.beats == LEN_W'(1)) begin
                        if (eng_q.cur_w == eng_q.ceil_w) begin
                            eng_d.eof0 = ~eng_q.sel;
                            eng_d.eof1 = eng_q.sel;
                            eng_d.sel  = ctrl.dual ? ~eng_q.sel : 1'b0;
                            eng_d.st   = ctrl.run ? ST_START : ST_IDLE;
                        end else begin
                            eng_d.st   = ctrl.run ? ST_GAP : ST_IDLE;
                        end
                        if (!ctrl.run) eng_d.sel = 1'b0;
                    end
                end
            end
            ST_GAP: begin
                eng_d.st = ST_REQ;
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mem_req    = req_c;
    assign mem_addr   = {eng_q.cur_w, 2'b00};
    assign mem_len    = len;
    assign fifo_wr    = eng_q.wr;
    assign fifo_wdata = eng_q.wdata;
    assign pix_ready  = eng_q.ready;
    assign eof0       = eng_q.eof0;
    assign eof1       = eng_q.eof1;
    assign underflow  = eng_q.uflow;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_accept |=> mem_req && $stable(mem_addr) && $stable(mem_len)); // R11

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (mem_len <= (LEN_W'(1) << MAX_BURST_LOG))); // R4

    AST_NO_PAST_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ({1'b0, mem_addr[AW-1:2]} + RW'(mem_len) - RW'(1)) <= {1'b0, eng_q.ceil_w}); // R5

    AST_EOF_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof0 && eof1)); // R3

    AST_WR_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(mem_rvalid)); // R11

    AST_NO_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |-> !mem_req); // R11

endmodule

// File: tb/test_fb_fetch_engine.sv
`timescale 1ns/1ps
module test_fb_fetch_engine;

    localparam int AW = 32;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_accept;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic [8:0]  level = '0;
    logic        pix_pop = 1'b0;
    logic        fifo_wr;
    logic [31:0] fifo_wdata;
    logic        pix_ready, eof0, eof1, underflow;

    always #10 clk = ~clk;

    fb_fetch_engine #(.AW(AW), .FIFO_DEPTH(DEPTH), .MAX_BURST_LOG(4)) i_fb_fetch_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_accept(mem_accept),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .fifo_level(level), .pix_pop(pix_pop),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .pix_ready(pix_ready),
        .eof0(eof0), .eof1(eof1), .underflow(underflow)
    );

    int total = 0;
    int bad = 0;

    logic [31:0] b_addr [64];
    logic [4:0]  b_len  [64];
    logic [31:0] w_log  [256];
    logic        e_log  [16];
    int nb = 0, nw = 0, ne = 0, ne1 = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[9:2] ^ 8'hA0, a[9:2] ^ 8'h5B, a[9:2] ^ 8'hC6, a[9:2] ^ 8'h3D};
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit run, input int thr, input int bl,
                                            input bit bsw, input bit hsw, input bit dual);
        return (32'(run) << 12) | (32'(thr) << 8) | (32'(bl) << 4) |
               (32'(bsw) << 3) | (32'(hsw) << 1) | 32'(dual);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory responder and FIFO / flag monitor
    initial begin
        int mstate;
        int mcnt;
        logic [31:0] maddr;
        mstate = 0; mcnt = 0; maddr = '0;
        mem_accept = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fifo_wr) begin
                    if (nw < 256) w_log[nw] = fifo_wdata;
                    nw++;
                    level = level + 9'd1;
                end
                if (eof0) begin if (ne < 16) e_log[ne] = 1'b0; ne++; end
                if (eof1) begin if (ne < 16) e_log[ne] = 1'b1; ne++; ne1++; end
            end
            #1;
            case (mstate)
                0: if (mem_req) begin
                       if (nb < 64) begin b_addr[nb] = mem_addr; b_len[nb] = mem_len; end
                       nb++;
                       maddr = mem_addr; mcnt = int'(mem_len);
                       mem_accept = 1'b1; mstate = 1;
                   end
                1: begin
                       mem_accept = 1'b0; mem_rvalid = 1'b1; mem_rdata = pat(maddr);
                       maddr += 4; mcnt--; mstate = 2;
                   end
                default: begin
                       if (mcnt == 0) begin mem_rvalid = 1'b0; mstate = 0; end
                       else begin mem_rdata = pat(maddr); maddr += 4; mcnt--; end
                   end
            endcase
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_buf(input int b, input logic [31:0] base, input int words);
        cfg_write(b == 0 ? 3'd1 : 3'd3, base);
        cfg_write(b == 0 ? 3'd2 : 3'd4, base + 32'(words * 4) - 32'd1);
    endtask

    task automatic wait_bursts(input int n);
        while (nb < n) @(negedge clk);
    endtask

    task automatic stop_and_clear();
        cfg_write(3'd0, 32'd0);
        repeat (40) @(negedge clk);
        nb = 0; nw = 0; ne = 0; ne1 = 0; level = '0;
    endtask

    task automatic t_reset();
        check(!mem_req && !fifo_wr, "R1 req/wr idle", {30'd0, mem_req, fifo_wr}, 0);
        check(!eof0 && !eof1, "R1 eof idle", {30'd0, eof0, eof1}, 0);
        check(!pix_ready && !underflow, "R1 flags idle", {30'd0, pix_ready, underflow}, 0);
    endtask

    task automatic t_single();
        set_buf(0, 32'h100, 16);
        cfg_write(3'd0, mk_ctrl(1, 0, 2, 0, 0, 0));
        wait_bursts(8);
        for (int i = 0; i < 8; i++) begin
            check(b_addr[i] == 32'h100 + 32'(16 * (i % 4)), "R2 single-mode address", b_addr[i], 32'h100 + 32'(16 * (i % 4)));
            check(b_len[i] == 5'd4, "R4 burst code 2", 32'(b_len[i]), 4);
        end
        for (int i = 0; i < 16; i++)
            check(w_log[i] == pat(32'h100 + 32'(4 * i)), "R11 data order", w_log[i], pat(32'h100 + 32'(4 * i)));
        check(ne >= 1 && ne1 == 0, "R2 only eof0", 32'(ne1), 0);
        stop_and_clear();
        repeat (10) @(negedge clk);
        check(nb == 0, "R12 stopped engine idle", 32'(nb), 0);
    endtask

    task automatic t_dual();
        set_buf(0, 32'h200, 8);
        set_buf(1, 32'h400, 4);
        cfg_write(3'd0, mk_ctrl(1, 0, 3, 0, 0, 1));
        wait_bursts(4);
        check(b_addr[0] == 32'h200 && b_len[0] == 5'd8, "R3 first pass buffer 0 (R12 start)", b_addr[0], 32'h200);
        check(b_addr[1] == 32'h400 && b_len[1] == 5'd4, "R3 second pass buffer 1", b_addr[1], 32'h400);
        check(b_addr[2] == 32'h200, "R3 third pass buffer 0", b_addr[2], 32'h200);
        check(b_addr[3] == 32'h400, "R3 fourth pass buffer 1", b_addr[3], 32'h400);
        check(ne >= 2 && e_log[0] == 1'b0 && e_log[1] == 1'b1, "R3 eof order", {31'd0, e_log[1]}, 1);
        stop_and_clear();
    endtask

    task automatic t_trunc();
        set_buf(0, 32'h302, 10);   // low bits of start ignored, ceiling 0x327
        cfg_write(3'd2, 32'h327);
        cfg_write(3'd0, mk_ctrl(1, 0, 2, 0, 0, 0));
        wait_bursts(4);
        check(b_addr[0] == 32'h300 && b_len[0] == 5'd4, "R5 burst 0", b_addr[0], 32'h300);
        check(b_addr[1] == 32'h310 && b_len[1] == 5'd4, "R5 burst 1", b_addr[1], 32'h310);
        check(b_addr[2] == 32'h320 && b_len[2] == 5'd2, "R5 truncated last burst", 32'(b_len[2]), 2);
        check(b_addr[3] == 32'h300, "R5 wrap to start", b_addr[3], 32'h300);
        stop_and_clear();
    endtask

    task automatic t_burst_codes();
        set_buf(0, 32'h800, 40);
        cfg_write(3'd0, mk_ctrl(1, 0, 7, 0, 0, 0));
        wait_bursts(3);
        check(b_len[0] == 5'd16 && b_len[1] == 5'd16, "R4 code 7 means 16", 32'(b_len[0]), 16);
        check(b_len[2] == 5'd8, "R4 code 7 tail truncated", 32'(b_len[2]), 8);
        stop_and_clear();
        set_buf(0, 32'h900, 3);
        cfg_write(3'd0, mk_ctrl(1, 0, 0, 0, 0, 0));
        wait_bursts(3);
        for (int i = 0; i < 3; i++)
            check(b_len[i] == 5'd1 && b_addr[i] == 32'h900 + 32'(4 * i), "R4 code 0 single words", b_addr[i], 32'h900 + 32'(4 * i));
        stop_and_clear();
    endtask

    task automatic t_latch();
        set_buf(0, 32'h100, 16);
        cfg_write(3'd0, mk_ctrl(1, 0, 4, 0, 0, 0));
        wait_bursts(1);
        set_buf(0, 32'h600, 16);
        wait_bursts(3);
        check(b_addr[0] == 32'h100, "R6 running pass keeps old start", b_addr[0], 32'h100);
        check(b_addr[1] == 32'h600, "R6 next pass uses new start", b_addr[1], 32'h600);
        check(b_len[1] == 5'd16, "R6 new ceiling length", 32'(b_len[1]), 16);
        stop_and_clear();
    endtask

    task automatic t_order(input bit bsw, input bit hsw, input string tag);
        logic [31:0] d, e;
        set_buf(0, 32'h700, 4);
        cfg_write(3'd0, mk_ctrl(1, 0, 2, bsw, hsw, 0));
        while (nw < 2) @(negedge clk);
        d = pat(32'h704);
        if (bsw && hsw)  e = {d[7:0], d[15:8], d[23:16], d[31:24]};
        else if (bsw)    e = {d[23:16], d[31:24], d[7:0], d[15:8]};
        else if (hsw)    e = {d[15:0], d[31:16]};
        else             e = d;
        check(w_log[1] == e, tag, w_log[1], e);
        stop_and_clear();
    endtask

    task automatic t_ready(input int k, input int lvl, input bit exp);
        cfg_write(3'd0, mk_ctrl(0, k, 0, 0, 0, 0));
        @(negedge clk); level = 9'(lvl);
        @(negedge clk); @(negedge clk);
        check(pix_ready == exp, "R8 threshold", 32'(pix_ready), 32'(exp));
        level = '0;
    endtask

    task automatic t_underflow();
        @(negedge clk); level = '0; pix_pop = 1'b1;
        @(negedge clk); pix_pop = 1'b0;
        check(underflow == 1'b1, "R9 pop on empty flagged", 32'(underflow), 1);
        @(negedge clk);
        check(underflow == 1'b0, "R9 one-cycle pulse", 32'(underflow), 0);
        level = 9'd3; pix_pop = 1'b1;
        @(negedge clk); pix_pop = 1'b0;
        check(underflow == 1'b0, "R9 pop on non-empty", 32'(underflow), 0);
        level = '0;
    endtask

    task automatic t_room();
        set_buf(0, 32'h100, 16);
        @(negedge clk); level = 9'd250;
        cfg_write(3'd0, mk_ctrl(1, 0, 3, 0, 0, 0));
        repeat (20) @(negedge clk);
        check(nb == 0, "R10 no burst without room", 32'(nb), 0);
        level = 9'd248;
        repeat (6) @(negedge clk);
        check(nb == 1 && b_len[0] == 5'd8, "R10 burst once room exists", 32'(nb), 1);
        stop_and_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_dual();
        t_trunc();
        t_burst_codes();
        t_latch();
        t_order(0, 0, "R7 plain order");
        t_order(1, 0, "R7 byte swap in halves");
        t_order(0, 1, "R7 half exchange");
        t_order(1, 1, "R7 full reversal");
        t_ready(0, 7, 0);
        t_ready(0, 8, 1);
        t_ready(1, 15, 0);
        t_ready(1, 16, 1);
        t_ready(7, 255, 0);
        t_ready(7, 256, 1);
        t_underflow();
        t_room();
        // R13: select codes exercised through every buffer setup above
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule